// File: doc/BRIEF.md
# Addressed Serial Register Read Slave

This block is the serial read port of a 32-channel digital input module. A host reaches it over four wires: an active-low slave select, a serial clock, a host-to-slave data line and a slave-to-host data line (MISO). A fifth wire, the phase line, splits every transaction into two phases. While the phase line is high, the bits the host shifts in fill an address shift register. When the phase line drops, the register picked by that address takes a snapshot of its parallel value. The host then clocks the snapshot out on MISO.

Two registers can be read. The identification register is a constant set by a parameter. The data register holds the 32 input channels, arranged as 8 banks of 4. Every serial input is resynchronised into the system clock `clk` and examined there for edges. An edge on a serial wire therefore shows up at the ports a few system clocks later, and the serial clock must run well below `clk`. Raising slave select ends the transaction and clears the address state.

Top module: `srs_slave`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `miso` is 0.
- R2: While `ss_n` is high, `miso` is 0. Activity on `ser_clk`, `mosi` and `addr_phase` while `ss_n` is high changes no address state.
- R3: While `ss_n` is low and `addr_phase` is high, each rising edge of `ser_clk` shifts `mosi` into a 16-bit address register, MSB first. If more than 16 bits arrive, only the last 16 are kept.
- R4: Address code 0x0000 selects the identification register, whose value is the parameter `ID_VALUE`.
- R5: Address code 0x0001 selects the data register. Bit i of that register is channel i (`chan_in[i]`), so bank b occupies bits 4b+3..4b. The register is sent from channel 31 down to channel 0.
- R6: The selected register captures its value at the falling edge of `addr_phase` (with `ss_n` low). Later changes on `chan_in` do not change the bits being sent.
- R7: Right after capture, `miso` shows the MSB. Each falling edge of `ser_clk` in the register phase moves `miso` to the next bit. Once all 32 bits have been sent, `miso` stays 0.
- R8: Any address code other than 0x0000 and 0x0001 selects nothing, and `miso` sends only zeros.
- R9: A rising edge of `ss_n` clears the address register and the sent-bit counter. A partial address from an aborted transaction therefore does not affect the next one, and a transaction that shifts in no address bits reads the identification register.
- R10: If the capture edge and a falling `ser_clk` edge are seen in the same system cycle, the capture takes priority. `miso` shows the MSB and no bit is skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic and all serial sampling run on it |
| rst | input | 1 | Synchronous active-high reset |
| ss_n | input | 1 | Active-low slave select |
| addr_phase | input | 1 | High: address phase; falling edge: capture; low: register phase |
| ser_clk | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial address bits from the host |
| chan_in | input | 32 | Parallel digital input channels, bit i = channel i |
| miso | output | 1 | Registered serial read data |

## Verification
Two things can happen in the same system cycle: the capture edge on `addr_phase` and the falling serial clock edge that shifts out the next bit. The bench forces this by leaving `ser_clk` high after the last address bit and then dropping both wires at the same instant, so their synchronised edges arrive together. The result is judged on the full bit stream that follows. The first bit sampled must be the register MSB, and the next falling edge must give bit 30, which shows the shift was neither done twice nor lost. A second overlap, slave select rising while shifting, is judged by `miso` returning to 0 and by the next transaction, which shifts in a single address bit and must still decode correctly.

// File: rtl/srs_pkg.sv
package srs_pkg;

  // Register selected by the decoded address code
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_ID   = 2'd1,
    SEL_DATA = 2'd2
  } sel_e;

  // Address code values; the decoder compares against these
  localparam int unsigned CODE_ID   = 0;
  localparam int unsigned CODE_DATA = 1;

endpackage

// File: rtl/srs_sync.sv
// Multi-stage synchroniser for asynchronous inputs, with a reset value
// per bit so that idle levels hold during reset.
module srs_sync #(
  parameter int unsigned         W       = 1,
  parameter int unsigned         STAGES  = 2,
  parameter logic [W-1:0]        RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/srs_addr_shift.sv
// Address handler: a shift register that takes one bit per enable pulse,
// MSB first, and clears when asked.
module srs_addr_shift #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [ADDR_W-1:0] addr
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      addr <= '0;
    end else if (shift_en) begin
      addr <= {addr[ADDR_W-2:0], bit_in};
    end
  end

endmodule

// File: rtl/srs_out_shift.sv
// Parallel-load, serial-out register with a sent-bit counter.
// Priority: clear, then load, then shift.
module srs_out_shift #(
  parameter int unsigned W     = 32,
  parameter int unsigned CNT_W = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic             shift,
  input  logic [W-1:0]     load_val,
  output logic             ser_out,
  output logic [CNT_W-1:0] sent
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(W);

  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sr      <= '0;
      ser_out <= 1'b0;
      sent    <= '0;
    end else if (load) begin
      ser_out <= load_val[W-1];
      sr      <= {load_val[W-2:0], 1'b0};
      sent    <= CNT_W'(1);
    end else if (shift) begin
      if (sent != LAST) begin
        ser_out <= sr[W-1];
        sr      <= {sr[W-2:0], 1'b0};
        sent    <= sent + CNT_W'(1);
      end else begin
        ser_out <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/srs_slave.sv
// Addressed serial register read slave: address phase, capture on the
// phase line falling, register phase with shift-out on the falling
// serial clock. All serial wires are oversampled in the system clock.
module srs_slave
  import srs_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned BANKS       = 8,
  parameter int unsigned CH_PER_BANK = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [BANKS*CH_PER_BANK-1:0] ID_VALUE = 32'hA5C3_0E21
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         ss_n,
  input  logic                         addr_phase,
  input  logic                         ser_clk,
  input  logic                         mosi,
  input  logic [BANKS*CH_PER_BANK-1:0] chan_in,
  output logic                         miso
);

  localparam int unsigned DATA_W = BANKS * CH_PER_BANK;
  localparam int unsigned CNT_W  = $clog2(DATA_W + 1);
  localparam int unsigned CTL_W  = 4;
  // idle levels: select high, phase high, clock low, data low
  localparam logic [CTL_W-1:0] CTL_IDLE = 4'b1100;

  // ---------------- control synchronisation ----------------
  logic [CTL_W-1:0] ctl_s;
  logic             ss_s, phase_s, sclk_s, mosi_s;
  logic             ss_prev, phase_prev, sclk_prev;

  srs_sync #(
    .W       (CTL_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (CTL_IDLE)
  ) u_ctl_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ss_n, addr_phase, ser_clk, mosi}),
    .q   (ctl_s)
  );

  assign {ss_s, phase_s, sclk_s, mosi_s} = ctl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      ss_prev    <= CTL_IDLE[3];
      phase_prev <= CTL_IDLE[2];
      sclk_prev  <= CTL_IDLE[1];
    end else begin
      ss_prev    <= ss_s;
      phase_prev <= phase_s;
      sclk_prev  <= sclk_s;
    end
  end

  // ---------------- edge events ----------------
  logic ss_act, ss_rise, sclk_rise, sclk_fall, cap_ev;
  logic addr_shift_en, out_shift_en;

  assign ss_act        = ~ss_s;
  assign ss_rise       = ss_s & ~ss_prev;
  assign sclk_rise     = sclk_s & ~sclk_prev;
  assign sclk_fall     = ~sclk_s & sclk_prev;
  assign cap_ev        = ss_act & phase_prev & ~phase_s;
  assign addr_shift_en = ss_act & phase_s & sclk_rise;
  assign out_shift_en  = ss_act & ~phase_s & sclk_fall;

  // ---------------- channel input synchronisation, per bank ----------------
  logic [DATA_W-1:0] chan_s;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    srs_sync #(
      .W       (CH_PER_BANK),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ('0)
    ) u_bank_sync (
      .clk (clk),
      .rst (rst),
      .d   (chan_in[b*CH_PER_BANK +: CH_PER_BANK]),
      .q   (chan_s[b*CH_PER_BANK +: CH_PER_BANK])
    );
  end

  // ---------------- address handler ----------------
  logic [ADDR_W-1:0] addr;

  srs_addr_shift #(
    .ADDR_W (ADDR_W)
  ) u_addr (
    .clk      (clk),
    .rst      (rst),
    .clr      (ss_rise),
    .shift_en (addr_shift_en),
    .bit_in   (mosi_s),
    .addr     (addr)
  );

  // ---------------- register select ----------------
  sel_e              sel;
  logic [DATA_W-1:0] sel_val;

  always_comb begin
    if (addr == ADDR_W'(CODE_ID))        sel = SEL_ID;
    else if (addr == ADDR_W'(CODE_DATA)) sel = SEL_DATA;
    else                                 sel = SEL_NONE;
  end

  always_comb begin
    unique case (sel)
      SEL_ID:   sel_val = ID_VALUE;
      SEL_DATA: sel_val = chan_s;
      default:  sel_val = '0;
    endcase
  end

  // ---------------- shift-out ----------------
  logic [CNT_W-1:0] sent_cnt;
  logic             ser_bit;

  srs_out_shift #(
    .W     (DATA_W),
    .CNT_W (CNT_W)
  ) u_out (
    .clk      (clk),
    .rst      (rst),
    .clr      (ss_s),
    .load     (cap_ev),
    .shift    (out_shift_en),
    .load_val (sel_val),
    .ser_out  (ser_bit),
    .sent     (sent_cnt)
  );

  assign miso = ser_bit;

endmodule

// File: rtl/srs_slave_chk.sv
// Property checker for srs_slave, attached with bind below.
module srs_slave_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 6,
  parameter logic [DATA_W-1:0] ID_VALUE = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              ss_s,
  input logic              phase_s,
  input logic              ss_rise,
  input logic              cap_ev,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  sent_cnt,
  input logic              miso
);

  AST_RST_QUIET: assert property (@(posedge clk) rst |=> !miso); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    ss_s |=> !miso); // R2

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ss_s && !phase_s) |=> $stable(addr)); // R3

  AST_ID_MSB: assert property (@(posedge clk) disable iff (rst)
    (cap_ev && addr == '0) |=> (miso == ID_VALUE[DATA_W-1])); // R4

  AST_NONE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cap_ev && addr > ADDR_W'(1)) |=> !miso); // R8

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sent_cnt == '0 || {1'b0, sent_cnt} <= {1'b0, $past(sent_cnt)} + 1'b1)); // R7

  AST_ADDR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ss_rise |=> (addr == '0)); // R9

  AST_CAP_FIRST: assert property (@(posedge clk) disable iff (rst)
    cap_ev |=> (sent_cnt == CNT_W'(1))); // R10

endmodule

bind srs_slave srs_slave_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .CNT_W    (CNT_W),
  .ID_VALUE (ID_VALUE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ss_s     (ss_s),
  .phase_s  (phase_s),
  .ss_rise  (ss_rise),
  .cap_ev   (cap_ev),
  .addr     (addr),
  .sent_cnt (sent_cnt),
  .miso     (miso)
);

// File: tb/sim_srs_slave.sv
module sim_srs_slave;

  localparam int          HALF = 6;   // system clocks per serial half period
  localparam logic [31:0] IDV  = 32'hA5C3_0E21;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ss_n = 1'b1;
  logic        addr_phase = 1'b1;
  logic        ser_clk = 1'b0;
  logic        mosi = 1'b0;
  logic [31:0] chan_in = '0;
  logic        miso;

  always #10 clk = ~clk;  // 50 MHz

  srs_slave #(.ID_VALUE(IDV)) u0 (
    .clk        (clk),
    .rst        (rst),
    .ss_n       (ss_n),
    .addr_phase (addr_phase),
    .ser_clk    (ser_clk),
    .mosi       (mosi),
    .chan_in    (chan_in),
    .miso       (miso)
  );

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic  v;
    string req;
  } exp_t;

  exp_t q[$];
  event smp_ev;

  // monitor: pops the next expected bit and compares it with miso
  always @(smp_ev) begin
    exp_t e;
    total++;
    if (q.size() == 0) begin
      bad++;
      $display("FAIL scoreboard: sample with empty queue, actual=%0b expected=none", miso);
    end else begin
      e = q.pop_front();
      if (miso !== e.v) begin
        bad++;
        $display("FAIL %s: miso actual=%0b expected=%0b", e.req, miso, e.v);
      end
    end
  end

  task automatic wait_half();
    repeat (HALF) @(negedge clk);
  endtask

  // driver side: push the expected value, then ask the monitor to sample
  task automatic expect_bit(input logic v, input string req);
    q.push_back('{v, req});
    -> smp_ev;
    #1;
  endtask

  // One read transaction: nbits address bits (MSB first), capture, then
  // 32 register bits plus 'extra' trailing bits that must be zero.
  task automatic read_txn(input logic [31:0] code, input int nbits,
                          input logic [31:0] expv, input int extra,
                          input bit collide, input bit mutate,
                          input string req);
    ss_n = 1'b0; addr_phase = 1'b1; ser_clk = 1'b0;
    wait_half();
    for (int i = nbits - 1; i >= 0; i--) begin
      mosi = code[i];
      wait_half();
      ser_clk = 1'b1;
      wait_half();
      if (!(collide && i == 0)) ser_clk = 1'b0;
    end
    // capture; with collide set the serial clock falls at the same instant
    addr_phase = 1'b0;
    ser_clk    = 1'b0;
    wait_half();
    wait_half();
    expect_bit(expv[31], req);
    for (int i = 30; i >= -extra; i--) begin
      ser_clk = 1'b1;
      wait_half();
      ser_clk = 1'b0;
      wait_half();
      if (mutate && i == 29) chan_in = ~chan_in;
      if (i >= 0) expect_bit(expv[i], req);
      else        expect_bit(1'b0, "R7");
    end
    ss_n = 1'b1; addr_phase = 1'b1;
    wait_half();
    wait_half();
    expect_bit(1'b0, "R2");
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    expect_bit(1'b0, "R1");
    rst = 1'b0;
    @(negedge clk);
    expect_bit(1'b0, "R1");
    wait_half();

    // R4: identification register, then trailing zeros (R7)
    read_txn(32'h0000, 16, IDV, 3, 1'b0, 1'b0, "R4");

    // R5: bank b holds value b, so channel order is visible
    chan_in = 32'h7654_3210;
    wait_half();
    read_txn(32'h0001, 16, 32'h7654_3210, 1, 1'b0, 1'b0, "R5");

    // R3: 20 bits shifted, only the last 16 (0x0001) count
    chan_in = 32'hDEAD_BEEF;
    wait_half();
    read_txn(32'h000F_0001, 20, 32'hDEAD_BEEF, 0, 1'b0, 1'b0, "R3");

    // R8: unused codes read as zeros
    read_txn(32'h8001, 16, 32'h0, 0, 1'b0, 1'b0, "R8");
    read_txn(32'h0100, 16, 32'h0, 0, 1'b0, 1'b0, "R8");

    // R6: inputs change in mid-read, the snapshot is sent unchanged
    chan_in = 32'h1357_9BDF;
    wait_half();
    read_txn(32'h0001, 16, 32'h1357_9BDF, 0, 1'b0, 1'b1, "R6");

    // R9: aborted partial address, then a one-bit address selects data
    chan_in = 32'hC0FF_EE11;
    ss_n = 1'b0; addr_phase = 1'b1;
    wait_half();
    for (int i = 0; i < 5; i++) begin
      mosi = 1'b1; wait_half(); ser_clk = 1'b1; wait_half(); ser_clk = 1'b0;
    end
    ss_n = 1'b1;
    wait_half();
    wait_half();
    read_txn(32'h0001, 1, 32'hC0FF_EE11, 0, 1'b0, 1'b0, "R9");
    read_txn(32'h0000, 0, IDV, 0, 1'b0, 1'b0, "R9");

    // R2: activity while deselected is ignored
    for (int i = 0; i < 6; i++) begin
      mosi = 1'b1; ser_clk = 1'b1; addr_phase = i[0];
      wait_half();
      expect_bit(1'b0, "R2");
      ser_clk = 1'b0;
      wait_half();
    end
    addr_phase = 1'b1;
    wait_half();
    read_txn(32'h0000, 0, IDV, 0, 1'b0, 1'b0, "R2");

    // R10: capture and falling serial clock in the same cycle
    chan_in = 32'h9ABC_DEF0;
    wait_half();
    read_txn(32'h0001, 16, 32'h9ABC_DEF0, 1, 1'b1, 1'b0, "R10");

    wait_half();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule